// File: doc/BRIEF.md
# Multi-Domain Ratio Clock-Enable Divider

This unit runs entirely on one fast reference clock and emits single-cycle clock-enable strobes for several downstream domains: processor, fast bus, slow bus, memory, display device and display pixel. It also emits a timer enable. Logic in each domain advances only on cycles where its strobe is high, so the whole chip keeps one clock tree while each domain runs at its own fraction of the reference rate.

The four system domains take a 4-bit ratio code that selects from a non-uniform set of ratios. The two display domains use plain binary fields that hold the ratio minus one. Both display domains count ticks of a peripheral source, and that source is either the reference clock itself or the reference clock halved. Software writes three words through a small register port: a control word, a pixel word and a gate word. A change-enable flag in the control word decides when newly written ratios reach the running counters. A counter never cuts a period short. It takes a new ratio only at its own terminal count.

Top module: `clkdiv_unit`

## Requirements
- R1: The system ratio codes 0 to 9 select the ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32, in that order. A running system strobe repeats with exactly that many reference cycles between pulses.
- R2: Any system ratio code from 10 to 15 behaves as ratio 1, so the strobe is high on every cycle.
- R3: The control word (address 0) holds the processor code in bits 3:0, the fast-bus code in bits 7:4, the slow-bus code in bits 11:8 and the memory code in bits 15:12.
- R4: Each divider produces exactly one strobe every N counted ticks, where N is its committed ratio. Ratio 1 gives a strobe on every counted tick.
- R5: The display-device ratio is control bits 20:16 plus one (1 to 32). It counts ticks of the peripheral source.
- R6: Control bit 21 picks the peripheral source. When it is 1, the source ticks on every reference cycle. When it is 0, the source ticks on every second reference cycle.
- R7: The pixel word (address 1, bits 10:0) plus one gives the pixel ratio (1 to 2048), counted in peripheral-source ticks.
- R8: Control bit 22 is the change-enable flag. While it is 1, the register contents are copied into the committed settings on every clock. While it is 0, the committed settings hold, and writes change only the stored words.
- R9: When the committed ratio of a divider changes, the divider completes its current period with the old ratio and then starts the new one.
- R10: Gate-word (address 2) bit 10 set to 1 stops the display-device and pixel strobes and holds both counters at reload. After the bit clears, the first strobe comes one full period later.
- R11: Gate-word bit 1 set to 1 holds the timer enable low. When the bit is 0, the timer enable is high.
- R12: The read port returns the control word in bits 22:0 with zeros above, the pixel word in bits 10:0 with zeros above, the full 32-bit gate word, and zero at address 3.
- R13: Synchronous active-high reset clears all three words and the committed settings. This gives ratio 1 on every system domain, source halved, change-enable off and nothing gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 pixel, 2 gate |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cpu_stb | output | 1 | Processor domain enable |
| fbus_stb | output | 1 | Fast-bus domain enable |
| sbus_stb | output | 1 | Slow-bus domain enable |
| mem_stb | output | 1 | Memory domain enable |
| disp_stb | output | 1 | Display-device domain enable |
| pix_stb | output | 1 | Display-pixel domain enable |
| tmr_stb | output | 1 | Timer domain enable |

## Verification
The tricky cycle is the one where a divider reaches its terminal count at the same moment that a write with change-enable set moves new ratios into the committed settings. In that cycle the divider must reload with the value that was committed before the edge, and only pick up the fresh value at the next period boundary. The bench provokes this by rewriting the control word at intervals that step through 1 to 13 cycles, so the writes fall on every counter phase. A behavioural model that predicts every strobe on every clock judges the result. Gate release is handled the same way: it is made to coincide with a source tick, and the model checks that a full period follows.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W   = 4;
    localparam int N_SYS    = 4;
    localparam int DISP_W   = 5;
    localparam int PIX_W    = 11;
    localparam int SYS_RW   = 6;
    localparam int DISP_RW  = DISP_W + 1;
    localparam int PIX_RW   = PIX_W + 1;
    localparam int DATA_W   = 32;

    localparam int DISP_LSB = N_SYS * CODE_W;
    localparam int SRC_BIT  = DISP_LSB + DISP_W;
    localparam int CE_BIT   = SRC_BIT + 1;
    localparam int CTRL_W   = CE_BIT + 1;

    localparam int GATE_DISP_BIT = 10;
    localparam int GATE_TMR_BIT  = 1;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_PIX  = 2'd1,
        ADDR_GATE = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [N_SYS-1:0][CODE_W-1:0] sys_code;
        logic [DISP_W-1:0]            disp;
        logic                         src_undiv;
        logic [PIX_W-1:0]             pix;
    } ratio_cfg_t;

    function automatic logic [SYS_RW-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [SYS_RW-1:0] r;
        case (code)
            4'd0:    r = 6'd1;
            4'd1:    r = 6'd2;
            4'd2:    r = 6'd3;
            4'd3:    r = 6'd4;
            4'd4:    r = 6'd6;
            4'd5:    r = 6'd8;
            4'd6:    r = 6'd12;
            4'd7:    r = 6'd16;
            4'd8:    r = 6'd24;
            4'd9:    r = 6'd32;
            default: r = 6'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold,
    input  logic [RW-1:0] ratio,
    output logic          stb
);
    logic [RW-1:0] cnt;
    logic [RW-1:0] cur;
    logic          term;

    assign term = (cnt == cur - RW'(1));
    assign stb  = tick & term & ~hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cur <= RW'(1);
        end else if (hold) begin
            cnt <= '0;
            cur <= ratio;
        end else if (tick) begin
            if (term) begin
                cnt <= '0;
                cur <= ratio;
            end else begin
                cnt <= cnt + RW'(1);
            end
        end
    end
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ratio_cfg_t        cfg,
    output logic              ce_flag,
    output logic              gate_disp,
    output logic              gate_tmr
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [PIX_W-1:0]  pix_q;
    logic [DATA_W-1:0] gate_q;
    ratio_cfg_t        staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pix_q  <= '0;
            gate_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                ADDR_PIX:  pix_q  <= wr_data[PIX_W-1:0];
                ADDR_GATE: gate_q <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        staged.sys_code  = ctrl_q[DISP_LSB-1:0];
        staged.disp      = ctrl_q[SRC_BIT-1:DISP_LSB];
        staged.src_undiv = ctrl_q[SRC_BIT];
        staged.pix       = pix_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                 cfg <= '0;
        else if (ctrl_q[CE_BIT]) cfg <= staged;
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADDR_CTRL: rd_data = DATA_W'(ctrl_q);
            ADDR_PIX:  rd_data = DATA_W'(pix_q);
            ADDR_GATE: rd_data = gate_q;
            default:   rd_data = '0;
        endcase
    end

    assign ce_flag   = ctrl_q[CE_BIT];
    assign gate_disp = gate_q[GATE_DISP_BIT];
    assign gate_tmr  = gate_q[GATE_TMR_BIT];
endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        cpu_stb,
    output logic        fbus_stb,
    output logic        sbus_stb,
    output logic        mem_stb,
    output logic        disp_stb,
    output logic        pix_stb,
    output logic        tmr_stb
);
    ratio_cfg_t       cfg;
    logic             ce_flag;
    logic             gate_disp;
    logic             gate_tmr;
    logic             src_phase;
    logic             src_tick;
    logic [N_SYS-1:0] sys_stb;

    clkdiv_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg       (cfg),
        .ce_flag   (ce_flag),
        .gate_disp (gate_disp),
        .gate_tmr  (gate_tmr)
    );

    // Peripheral source: every cycle, or every second cycle
    always_ff @(posedge clk) begin
        if (rst) src_phase <= 1'b0;
        else     src_phase <= ~src_phase;
    end
    assign src_tick = cfg.src_undiv | src_phase;

    for (genvar i = 0; i < N_SYS; i++) begin : g_sys
        clkdiv_counter #(.RW(SYS_RW)) u_div (
            .clk   (clk),
            .rst   (rst),
            .tick  (1'b1),
            .hold  (1'b0),
            .ratio (code_ratio(cfg.sys_code[i])),
            .stb   (sys_stb[i])
        );
    end

    clkdiv_counter #(.RW(DISP_RW)) u_disp (
        .clk   (clk),
        .rst   (rst),
        .tick  (src_tick),
        .hold  (gate_disp),
        .ratio (DISP_RW'(cfg.disp) + DISP_RW'(1)),
        .stb   (disp_stb)
    );

    clkdiv_counter #(.RW(PIX_RW)) u_pix (
        .clk   (clk),
        .rst   (rst),
        .tick  (src_tick),
        .hold  (gate_disp),
        .ratio (PIX_RW'(cfg.pix) + PIX_RW'(1)),
        .stb   (pix_stb)
    );

    assign cpu_stb  = sys_stb[0];
    assign fbus_stb = sys_stb[1];
    assign sbus_stb = sys_stb[2];
    assign mem_stb  = sys_stb[3];
    assign tmr_stb  = ~gate_tmr;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [1:0]  rd_addr,
    input logic [31:0] rd_data,
    input logic        disp_stb,
    input logic        tmr_stb,
    input logic        ce_flag,
    input ratio_cfg_t  cfg
);
    assert_reset_state_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ce_flag && cfg == '0 && tmr_stb));

    assert_pix_readback_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=>
            (rd_addr != 2'd1 || rd_data == {21'b0, $past(wr_data[10:0])}));

    assert_gate_readback_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=> (rd_addr != 2'd2 || rd_data == $past(wr_data)));

    assert_timer_gate_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=> (tmr_stb == !$past(wr_data[1])));

    assert_commit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ce_flag |=> $stable(cfg));

    assert_halved_source_R6: assert property (@(posedge clk) disable iff (rst)
        (disp_stb && !cfg.src_undiv) |=> (!disp_stb || cfg.src_undiv));
endmodule

bind clkdiv_unit clkdiv_checker i_clkdiv_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .disp_stb (disp_stb),
    .tmr_stb  (tmr_stb),
    .ce_flag  (ce_flag),
    .cfg      (cfg)
);

// File: tb/test_clkdiv_unit.sv
module test_clkdiv_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic cpu_stb, fbus_stb, sbus_stb, mem_stb, disp_stb, pix_stb, tmr_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_unit i_clkdiv_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cpu_stb(cpu_stb), .fbus_stb(fbus_stb),
        .sbus_stb(sbus_stb), .mem_stb(mem_stb), .disp_stb(disp_stb), .pix_stb(pix_stb),
        .tmr_stb(tmr_stb)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural model state
    logic [22:0] m_ctrl = '0;
    logic [10:0] m_pix  = '0;
    logic [31:0] m_gate = '0;
    int  c_code [4] = '{0, 0, 0, 0};
    int  c_disp = 0;
    int  c_pix  = 0;
    bit  c_sel  = 1'b0;
    bit  m_phase = 1'b0;
    int  m_cnt [6] = '{0, 0, 0, 0, 0, 0};
    int  m_cur [6] = '{1, 1, 1, 1, 1, 1};

    function automatic int sys_ratio(int code);
        int tbl [10] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32};
        return (code < 10) ? tbl[code] : 1;
    endfunction

    function automatic bit stb_of(int idx);
        case (idx)
            0: return cpu_stb;
            1: return fbus_stb;
            2: return sbus_stb;
            3: return mem_stb;
            4: return disp_stb;
            default: return pix_stb;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One reference cycle: compare outputs with the model, advance the model, move to next negedge
    task automatic step();
        bit srct;
        logic [31:0] exp_rd;
        int nn [6];
        bit tk [6];
        bit hd [6];
        #1;
        srct = c_sel ? 1'b1 : m_phase;
        for (int i = 0; i < 4; i++)
            chk(stb_of(i) == (m_cnt[i] == m_cur[i] - 1), "R4 system strobe", stb_of(i),
                m_cnt[i] == m_cur[i] - 1);
        chk(disp_stb == (srct && m_cnt[4] == m_cur[4] - 1 && !m_gate[10]), "R5 display strobe",
            disp_stb, srct && m_cnt[4] == m_cur[4] - 1 && !m_gate[10]);
        chk(pix_stb == (srct && m_cnt[5] == m_cur[5] - 1 && !m_gate[10]), "R7 pixel strobe",
            pix_stb, srct && m_cnt[5] == m_cur[5] - 1 && !m_gate[10]);
        chk(tmr_stb == !m_gate[1], "R11 timer enable", tmr_stb, !m_gate[1]);
        case (rd_addr)
            2'd0: exp_rd = {9'b0, m_ctrl};
            2'd1: exp_rd = {21'b0, m_pix};
            2'd2: exp_rd = m_gate;
            default: exp_rd = 32'd0;
        endcase
        chk(rd_data == exp_rd, "R12 read data", rd_data, exp_rd);

        if (rst) begin
            m_ctrl = '0; m_pix = '0; m_gate = '0;
            for (int i = 0; i < 4; i++) c_code[i] = 0;
            c_disp = 0; c_pix = 0; c_sel = 1'b0; m_phase = 1'b0;
            for (int i = 0; i < 6; i++) begin m_cnt[i] = 0; m_cur[i] = 1; end
        end else begin
            for (int i = 0; i < 4; i++) begin
                tk[i] = 1'b1; hd[i] = 1'b0; nn[i] = sys_ratio(c_code[i]);
            end
            tk[4] = srct; hd[4] = m_gate[10]; nn[4] = c_disp + 1;
            tk[5] = srct; hd[5] = m_gate[10]; nn[5] = c_pix + 1;
            // R9: new ratio taken only at period end (or while held)
            for (int i = 0; i < 6; i++) begin
                if (hd[i]) begin
                    m_cnt[i] = 0; m_cur[i] = nn[i];
                end else if (tk[i]) begin
                    if (m_cnt[i] == m_cur[i] - 1) begin
                        m_cnt[i] = 0; m_cur[i] = nn[i];
                    end else begin
                        m_cnt[i]++;
                    end
                end
            end
            if (m_ctrl[22]) begin
                for (int i = 0; i < 4; i++) c_code[i] = int'(m_ctrl[4*i +: 4]);
                c_disp = int'(m_ctrl[20:16]);
                c_sel  = m_ctrl[21];
                c_pix  = int'(m_pix);
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_ctrl = wr_data[22:0];
                    2'd1: m_pix  = wr_data[10:0];
                    2'd2: m_gate = wr_data;
                    default: ;
                endcase
            end
            m_phase = !m_phase;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(logic [1:0] a, logic [31:0] exp, string tag);
        rd_addr = a;
        #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic period(int idx, int exp, string tag);
        int p = 0;
        int guard = 0;
        while (!stb_of(idx) && guard < 5000) begin step(); guard++; end
        do begin step(); p++; end while (!stb_of(idx) && p < 5000);
        chk(p == exp, tag, p, exp);
    endtask

    function automatic logic [31:0] ctrl_word(int cpu, int fb, int sb, int mem, int dsp,
                                              bit sel, bit ce);
        return 32'(cpu) | (32'(fb) << 4) | (32'(sb) << 8) | (32'(mem) << 12) |
               (32'(dsp) << 16) | (32'(sel) << 21) | (32'(ce) << 22);
    endfunction

    initial begin
        int cnt;
        @(negedge clk);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        // R13: reset state
        rdchk(2'd0, 32'd0, "R13 control after reset");
        rdchk(2'd1, 32'd0, "R13 pixel after reset");
        rdchk(2'd2, 32'd0, "R13 gate after reset");
        chk(tmr_stb == 1'b1, "R13 timer runs after reset", tmr_stb, 1);
        period(0, 1, "R13 processor ratio 1 after reset");

        // R3: field positions
        wr(2'd0, ctrl_word(2, 5, 9, 12, 3, 1'b1, 1'b1));
        run(120);
        period(0, 3,  "R3 processor code 2");
        period(1, 8,  "R3 fast bus code 5");
        period(2, 32, "R3 slow bus code 9");
        period(3, 1,  "R2 memory code 12");
        period(4, 4,  "R5 display field 3 undivided source");

        // R8: change-enable off holds committed ratios
        wr(2'd0, ctrl_word(7, 5, 9, 12, 3, 1'b1, 1'b0));
        run(80);
        period(0, 3, "R8 processor held while change-enable clear");
        rdchk(2'd0, ctrl_word(7, 5, 9, 12, 3, 1'b1, 1'b0), "R12 control readback");
        wr(2'd0, ctrl_word(7, 5, 9, 12, 3, 1'b1, 1'b1));
        run(60);
        period(0, 16, "R8 processor code 7 after commit");

        // R6: halved source
        wr(2'd0, ctrl_word(1, 0, 0, 0, 3, 1'b0, 1'b1));
        run(40);
        period(4, 8, "R6 display field 3 halved source");

        // R7: pixel divider
        wr(2'd1, 32'd4);
        run(40);
        period(5, 10, "R7 pixel field 4 halved source");
        wr(2'd1, 32'd300);
        wr(2'd0, ctrl_word(1, 0, 0, 0, 3, 1'b1, 1'b1));
        run(700);
        period(5, 301, "R7 pixel field 300 undivided source");
        wr(2'd1, 32'd2);

        // R10: display gating
        run(20);
        wr(2'd2, 32'h400);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin step(); cnt += disp_stb + pix_stb; end
        chk(cnt == 0, "R10 display and pixel stopped while gated", cnt, 0);
        wr(2'd2, 32'h0);
        cnt = 1;
        while (!disp_stb && cnt < 100) begin step(); cnt++; end
        chk(cnt == 4, "R10 full display period after ungating", cnt, 4);

        // R11: timer gate
        wr(2'd2, 32'h2);
        chk(tmr_stb == 1'b0, "R11 timer stopped", tmr_stb, 0);
        wr(2'd2, 32'h0);
        chk(tmr_stb == 1'b1, "R11 timer running", tmr_stb, 1);

        // R12: unused bits, unused address
        wr(2'd0, 32'hFFFF_FFFF);
        rdchk(2'd0, 32'h007F_FFFF, "R12 control upper bits read zero");
        wr(2'd1, 32'hFFFF_FFFF);
        rdchk(2'd1, 32'h0000_07FF, "R12 pixel upper bits read zero");
        rdchk(2'd3, 32'd0, "R12 address 3 reads zero");
        wr(2'd1, 32'd6);

        // R1 / R2: full code sweep
        for (int c = 0; c < 16; c++) begin
            wr(2'd0, ctrl_word(c, 15 - c, c, 0, c, c[0], 1'b1));
            run(70);
            period(0, sys_ratio(c), c < 10 ? "R1 code table" : "R2 code above 9");
        end

        // R9: writes landing at every counter phase
        for (int k = 1; k <= 13; k++) begin
            rd_addr = 2'(k);
            wr(2'd0, ctrl_word(k % 10, (k * 3) % 16, (k + 4) % 10, k % 7, k, k[1], 1'b1));
            run(k);
            if (k % 4 == 0) wr(2'd2, 32'(k[2]) << 10);
            run(k + 3);
        end
        wr(2'd2, 32'h0);
        run(400);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule